// File: doc/BRIEF.md
# Mixed-Aspect Two-Clock Block RAM

This block models a 4096-bit memory with one write port and one read port. Each port has its own clock. The write side and the read side each pick an access width of 16, 8, 4 or 2 bits through a 2-bit aspect parameter: 0 = 16 bits, 1 = 8 bits, 2 = 4 bits, 3 = 2 bits. Both data buses are always 16 bits wide.

In the narrower aspects the data does not sit in the low bits of the bus. It travels on fixed, spread-out lanes. Because of this, a word written narrow and then read at full width shows up in exactly those lanes. Lanes that carry no data read back as zero.

The storage is 256 words of 16 bits. An aspect of width 16/2^m uses address bits [7+m:0]:
- bits [7+m:m] select the word;
- bits [m-1:0] select which physical bits of that word are touched.

Each clock can be made falling-edge active by a parameter. The read data sits in a register. That register takes a new value only when both read qualifiers are high, and an active-high synchronous reset on the read clock clears it.

Top module: `aspect_bram`

## Requirements
- R1: With both aspects at 16 bits, a write stores all 16 data bits in word addr[7:0], and a later read of that word returns them on rdata[15:0].
- R2: A write changes storage only on an active write-clock edge at which both the write clock enable and the write enable are 1.
- R3: rdata loads on an active read-clock edge only when both the read clock enable and the read enable are 1. Otherwise it keeps its value.
- R4: In the 16-bit write aspect, a wmask bit of 1 keeps the stored bit at that position unchanged, while bits with mask 0 take the new data.
- R5: In the 8-, 4- and 2-bit write aspects, wmask has no effect.
- R6: In the 8-bit aspect, logical bit k travels on bus lane 2k and is stored in physical bit 2k+addr[0] of word addr[8:1].
- R7: In the 4-bit aspect, logical bit k travels on lane 4k+1 (lanes 1, 5, 9, 13) and is stored in physical bit 4k+(addr[1:0] XOR 1) of word addr[9:2].
- R8: In the 2-bit aspect, logical bit k travels on lane 8k+3 (lanes 3, 11) and is stored in physical bit 8k+(addr[2:0] XOR 3) of word addr[10:3].
- R9: In a narrow read aspect, every rdata lane that carries no data reads 0.
- R10: Address bits above those the aspect uses are ignored on both ports.
- R11: A read and a write of the same word on the same edge return the contents from before the write.
- R12: With a clock-invert parameter set to 1, that port acts on the falling edge of its clock.
- R13: rst high at an active read-clock edge clears rdata to 0. Reset takes priority over a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write port clock |
| rclk_i | input | 1 | Read port clock |
| rst_i | input | 1 | Synchronous active-high reset of the read register (read clock) |
| wclk_en_i | input | 1 | Write clock enable |
| wr_en_i | input | 1 | Write enable |
| waddr_i | input | 11 | Write address |
| wdata_i | input | 16 | Write data, lanes chosen by the write aspect |
| wmask_i | input | 16 | Per-bit write block, 1 = keep (16-bit aspect only) |
| rclk_en_i | input | 1 | Read clock enable |
| rd_en_i | input | 1 | Read enable |
| raddr_i | input | 11 | Read address |
| rdata_o | output | 16 | Registered read data, lanes chosen by the read aspect |

## Verification
A write and a read can hit the same word on one shared clock edge. The bench drives one clock into both ports to provoke this. It issues a masked write to a word while reading that word through an alias that differs only in ignored high address bits. It then expects the pre-write contents at that edge and the merged value on the next read. A separate falling-edge instance is sampled in mid-cycle, which proves it updated on the inverted edge.

// File: rtl/abram_pkg.sv
package abram_pkg;

    localparam int unsigned LANES   = 16;
    localparam int unsigned ADDR_W  = 11;
    localparam int unsigned WORD_AW = 8;
    localparam int unsigned SUB_W   = ADDR_W - WORD_AW;
    localparam int unsigned DEPTH   = 1 << WORD_AW;

    typedef logic [LANES-1:0]   lane_t;
    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [WORD_AW-1:0] word_t;
    typedef logic [SUB_W-1:0]   sub_t;

    typedef enum logic [1:0] {
        ASP_X16 = 2'd0,
        ASP_X8  = 2'd1,
        ASP_X4  = 2'd2,
        ASP_X2  = 2'd3
    } aspect_e;

    // word index and slot inside the word for one access
    typedef struct packed {
        word_t word;
        sub_t  sub;
    } loc_t;

    // lane that carries logical bit 0 in a given aspect
    function automatic int unsigned lane_base(int unsigned m);
        case (m)
            0, 1:    return 0;
            2:       return 1;
            default: return 3;
        endcase
    endfunction

    function automatic int unsigned slot_mask(int unsigned m);
        return (1 << m) - 1;
    endfunction

    function automatic loc_t split_addr(addr_t a, int unsigned m);
        loc_t l;
        l.word = word_t'(a >> m);
        l.sub  = sub_t'(a & addr_t'(slot_mask(m)));
        return l;
    endfunction

    // lanes that carry data in a given aspect
    function automatic lane_t live_lanes(int unsigned m);
        lane_t v;
        for (int p = 0; p < LANES; p++)
            v[p] = ((p & slot_mask(m)) == lane_base(m));
        return v;
    endfunction

endpackage

// File: rtl/abram_wr_map.sv
module abram_wr_map
    import abram_pkg::*;
#(
    parameter int unsigned MODE = 0
) (
    input  addr_t addr_i,
    input  lane_t data_i,
    input  lane_t mask_i,
    output word_t word_o,
    output lane_t bit_en_o,
    output lane_t bit_dat_o
);

    localparam int unsigned LOWM    = slot_mask(MODE);
    localparam int unsigned BASE    = lane_base(MODE);
    localparam bit          MASK_ON = (MODE == 0);

    loc_t loc;

    assign loc    = split_addr(addr_i, MODE);
    assign word_o = loc.word;

    // physical bit p holds logical bit (p >> MODE) of slot ((p & LOWM) ^ BASE)
    for (genvar p = 0; p < LANES; p++) begin : g_bit
        localparam int unsigned SRC  = (p & ~LOWM) | BASE;
        localparam sub_t        SLOT = sub_t'((p & LOWM) ^ BASE);
        assign bit_dat_o[p] = data_i[SRC];
        assign bit_en_o[p]  = (loc.sub == SLOT) && !(MASK_ON && mask_i[p]);
    end

endmodule

// File: rtl/abram_rd_map.sv
module abram_rd_map
    import abram_pkg::*;
#(
    parameter int unsigned MODE = 0
) (
    input  lane_t word_i,
    input  sub_t  sub_i,
    output lane_t data_o
);

    localparam int unsigned LOWM = slot_mask(MODE);
    localparam int unsigned BASE = lane_base(MODE);

    for (genvar p = 0; p < LANES; p++) begin : g_lane
        if ((p & LOWM) == BASE) begin : g_live
            localparam int unsigned HI = p & ~LOWM;
            logic [3:0] pick;
            assign pick      = 4'(HI) | (4'(sub_i) ^ 4'(BASE));
            assign data_o[p] = word_i[pick];
        end else begin : g_dead
            assign data_o[p] = 1'b0;
        end
    end

endmodule

// File: rtl/abram_array.sv
module abram_array
    import abram_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  wr_go_i,
    input  word_t wr_word_i,
    input  lane_t bit_en_i,
    input  lane_t bit_dat_i,
    input  word_t rd_word_i,
    output lane_t rd_word_o
);

    lane_t store [DEPTH];

    always_ff @(posedge clk_i) begin
        if (wr_go_i)
            store[wr_word_i] <= (store[wr_word_i] & ~bit_en_i) | (bit_dat_i & bit_en_i);
    end

    assign rd_word_o = store[rd_word_i];

    AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_go_i |=> store[$past(wr_word_i)] == $past(store[wr_word_i])); // R2

    AST_MASKED_BITS_KEEP: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_go_i |=> ((store[$past(wr_word_i)] ^ $past(store[wr_word_i])) & ~$past(bit_en_i)) == '0); // R4

endmodule

// File: rtl/aspect_bram.sv
module aspect_bram
    import abram_pkg::*;
#(
    parameter int unsigned WR_MODE  = 0,
    parameter int unsigned RD_MODE  = 0,
    parameter bit          WCLK_INV = 1'b0,
    parameter bit          RCLK_INV = 1'b0
) (
    input  logic        wclk_i,
    input  logic        rclk_i,
    input  logic        rst_i,
    input  logic        wclk_en_i,
    input  logic        wr_en_i,
    input  logic [10:0] waddr_i,
    input  logic [15:0] wdata_i,
    input  logic [15:0] wmask_i,
    input  logic        rclk_en_i,
    input  logic        rd_en_i,
    input  logic [10:0] raddr_i,
    output logic [15:0] rdata_o
);

    localparam lane_t RD_LIVE = live_lanes(RD_MODE);

    logic  wclk_act;
    logic  rclk_act;
    logic  wr_go;
    word_t wr_word;
    lane_t bit_en;
    lane_t bit_dat;
    loc_t  rd_loc;
    lane_t rd_word_data;
    lane_t rd_lanes;
    lane_t rdata_q;

    if (WCLK_INV) begin : g_wclk_neg
        assign wclk_act = ~wclk_i;
    end else begin : g_wclk_pos
        assign wclk_act = wclk_i;
    end

    if (RCLK_INV) begin : g_rclk_neg
        assign rclk_act = ~rclk_i;
    end else begin : g_rclk_pos
        assign rclk_act = rclk_i;
    end

    assign wr_go  = wclk_en_i & wr_en_i;
    assign rd_loc = split_addr(raddr_i, RD_MODE);

    abram_wr_map #(.MODE(WR_MODE)) u_wr_map (
        .addr_i    (waddr_i),
        .data_i    (wdata_i),
        .mask_i    (wmask_i),
        .word_o    (wr_word),
        .bit_en_o  (bit_en),
        .bit_dat_o (bit_dat)
    );

    abram_array u_array (
        .clk_i     (wclk_act),
        .rst_i     (rst_i),
        .wr_go_i   (wr_go),
        .wr_word_i (wr_word),
        .bit_en_i  (bit_en),
        .bit_dat_i (bit_dat),
        .rd_word_i (rd_loc.word),
        .rd_word_o (rd_word_data)
    );

    abram_rd_map #(.MODE(RD_MODE)) u_rd_map (
        .word_i (rd_word_data),
        .sub_i  (rd_loc.sub),
        .data_o (rd_lanes)
    );

    always_ff @(posedge rclk_act) begin
        if (rst_i)
            rdata_q <= '0;
        else if (rclk_en_i && rd_en_i)
            rdata_q <= rd_lanes;
    end

    assign rdata_o = rdata_q;

    AST_RESET_CLEAR: assert property (@(posedge rclk_act)
        rst_i |=> rdata_o == '0); // R13

    AST_READ_HOLD: assert property (@(posedge rclk_act) disable iff (rst_i)
        !(rclk_en_i && rd_en_i) |=> $stable(rdata_o)); // R3

    AST_DEAD_LANES: assert property (@(posedge rclk_act) disable iff (rst_i)
        (rdata_o & ~RD_LIVE) == '0); // R9

endmodule

// File: tb/test_aspect_bram.sv
module test_aspect_bram;

    logic        clk = 1'b0;
    logic        rst;
    logic        wce, we, rce, re;
    logic [10:0] waddr, raddr;
    logic [15:0] wdata, wmask;
    logic [15:0] rd_a, rd_b, rd_c, rd_d;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    // A: 16/16; B: write 8, read 16; C: write 16, read 4; D: 2/2 on falling edges
    aspect_bram #(.WR_MODE(0), .RD_MODE(0)) i_aspect_bram (
        .wclk_i(clk), .rclk_i(clk), .rst_i(rst), .wclk_en_i(wce), .wr_en_i(we),
        .waddr_i(waddr), .wdata_i(wdata), .wmask_i(wmask), .rclk_en_i(rce),
        .rd_en_i(re), .raddr_i(raddr), .rdata_o(rd_a));

    aspect_bram #(.WR_MODE(1), .RD_MODE(0)) i_aspect_bram_w8r16 (
        .wclk_i(clk), .rclk_i(clk), .rst_i(rst), .wclk_en_i(wce), .wr_en_i(we),
        .waddr_i(waddr), .wdata_i(wdata), .wmask_i(wmask), .rclk_en_i(rce),
        .rd_en_i(re), .raddr_i(raddr), .rdata_o(rd_b));

    aspect_bram #(.WR_MODE(0), .RD_MODE(2)) i_aspect_bram_w16r4 (
        .wclk_i(clk), .rclk_i(clk), .rst_i(rst), .wclk_en_i(wce), .wr_en_i(we),
        .waddr_i(waddr), .wdata_i(wdata), .wmask_i(wmask), .rclk_en_i(rce),
        .rd_en_i(re), .raddr_i(raddr), .rdata_o(rd_c));

    aspect_bram #(.WR_MODE(3), .RD_MODE(3), .WCLK_INV(1'b1), .RCLK_INV(1'b1)) i_aspect_bram_w2r2_neg (
        .wclk_i(clk), .rclk_i(clk), .rst_i(rst), .wclk_en_i(wce), .wr_en_i(we),
        .waddr_i(waddr), .wdata_i(wdata), .wmask_i(wmask), .rclk_en_i(rce),
        .rd_en_i(re), .raddr_i(raddr), .rdata_o(rd_d));

    typedef struct packed {
        logic        wce;
        logic        we;
        logic [10:0] wa;
        logic [15:0] wd;
        logic [15:0] wm;
        logic        rce;
        logic        re;
        logic [10:0] ra;
        logic [15:0] exp;
    } vec_t;

    // rows for instance A, one cycle each, expected rdata after that edge
    localparam int NVEC = 12;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b1, 11'h005, 16'hA5C3, 16'h0000, 1'b1, 1'b0, 11'h000, 16'h0000},
        '{1'b1, 1'b1, 11'h006, 16'h1234, 16'h0000, 1'b1, 1'b1, 11'h005, 16'hA5C3},
        '{1'b0, 1'b0, 11'h000, 16'h0000, 16'h0000, 1'b1, 1'b1, 11'h006, 16'h1234},
        '{1'b1, 1'b1, 11'h005, 16'hFFFF, 16'h00FF, 1'b1, 1'b1, 11'h006, 16'h1234},
        '{1'b0, 1'b0, 11'h000, 16'h0000, 16'h0000, 1'b1, 1'b1, 11'h005, 16'hFFC3},
        '{1'b1, 1'b1, 11'h105, 16'h0000, 16'hF0F0, 1'b1, 1'b1, 11'h705, 16'hFFC3},
        '{1'b0, 1'b0, 11'h000, 16'h0000, 16'h0000, 1'b1, 1'b1, 11'h005, 16'hF0C0},
        '{1'b0, 1'b1, 11'h005, 16'h0000, 16'h0000, 1'b1, 1'b1, 11'h005, 16'hF0C0},
        '{1'b1, 1'b0, 11'h005, 16'h0000, 16'h0000, 1'b1, 1'b1, 11'h006, 16'h1234},
        '{1'b0, 1'b0, 11'h000, 16'h0000, 16'h0000, 1'b0, 1'b1, 11'h005, 16'h1234},
        '{1'b0, 1'b0, 11'h000, 16'h0000, 16'h0000, 1'b1, 1'b0, 11'h005, 16'h1234},
        '{1'b0, 1'b0, 11'h000, 16'h0000, 16'h0000, 1'b1, 1'b1, 11'h005, 16'hF0C0}
    };

    task automatic drive(input logic wce_, input logic we_, input logic [10:0] wa,
                         input logic [15:0] wd, input logic [15:0] wm,
                         input logic rce_, input logic re_, input logic [10:0] ra);
        wce = wce_; we = we_; waddr = wa; wdata = wd; wmask = wm;
        rce = rce_; re = re_; raddr = ra;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        drive(0, 0, 11'h0, 16'h0, 16'h0, 0, 0, 11'h0);
        repeat (3) step();
        check("R13 reset A", rd_a, 16'h0000);
        check("R13 reset B", rd_b, 16'h0000);
        check("R13 reset C", rd_c, 16'h0000);
        check("R13 reset D", rd_d, 16'h0000);
        rst = 1'b0;

        // R1 R2 R3 R4 R10 R11 table on instance A
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i].wce, VEC[i].we, VEC[i].wa, VEC[i].wd, VEC[i].wm,
                  VEC[i].rce, VEC[i].re, VEC[i].ra);
            step();
            check($sformatf("R1/R2/R3/R4/R10/R11 row %0d", i), rd_a, VEC[i].exp);
        end

        // R6 R5: byte writes into word 0x0A of B, mask all ones, odd-lane noise
        drive(1, 1, 11'h014, 16'hEFBB, 16'hFFFF, 0, 0, 11'h0);
        step();
        drive(1, 1, 11'h015, 16'hAA55, 16'hFFFF, 0, 0, 11'h0);
        step();
        drive(0, 0, 11'h0, 16'h0, 16'h0, 1, 1, 11'h00A);
        step();
        check("R6 R5 byte lanes wide read B", rd_b, 16'h45BB);

        // R7 R9 R10: wide write, 4-bit reads on C
        drive(1, 1, 11'h033, 16'h2A5C, 16'h0000, 0, 0, 11'h0);
        step();
        drive(0, 0, 11'h0, 16'h0, 16'h0, 1, 1, 11'h0CC);
        step();
        check("R7 R9 slot0 C", rd_c, 16'h2200);
        drive(0, 0, 11'h0, 16'h0, 16'h0, 1, 1, 11'h0CD);
        step();
        check("R7 R9 slot1 C", rd_c, 16'h0020);
        drive(0, 0, 11'h0, 16'h0, 16'h0, 1, 1, 11'h0CE);
        step();
        check("R7 R9 slot2 C", rd_c, 16'h0202);
        drive(0, 0, 11'h0, 16'h0, 16'h0, 1, 1, 11'h0CF);
        step();
        check("R7 R9 slot3 C", rd_c, 16'h0022);
        drive(0, 0, 11'h0, 16'h0, 16'h0, 1, 1, 11'h4CF);
        step();
        check("R10 alias slot3 C", rd_c, 16'h0022);

        // R8 R12: 2-bit aspect on falling edges
        drive(1, 1, 11'h2A5, 16'h5804, 16'hFFFF, 0, 0, 11'h0);
        step();
        drive(1, 1, 11'h2A4, 16'h0008, 16'hFFFF, 0, 0, 11'h0);
        step();
        drive(0, 0, 11'h0, 16'h0, 16'h0, 1, 1, 11'h2A5);
        @(negedge clk);
        #1;
        check("R12 R8 falling-edge read D", rd_d, 16'h0800);
        step();
        drive(0, 0, 11'h0, 16'h0, 16'h0, 1, 1, 11'h2A4);
        step();
        check("R8 R9 slot4 D", rd_d, 16'h0008);

        // R13: reset beats an enabled read
        drive(0, 0, 11'h0, 16'h0, 16'h0, 1, 1, 11'h2A5);
        rst = 1'b1;
        step();
        check("R13 reset over read A", rd_a, 16'h0000);
        check("R13 reset over read B", rd_b, 16'h0000);
        check("R13 reset over read C", rd_c, 16'h0000);
        check("R13 reset over read D", rd_d, 16'h0000);
        rst = 1'b0;
        step();

        finish_run();
    end

endmodule